// File: doc/BRIEF.md
# Start-of-Transmission Dwell Monitor

This block observes one serial data lane while it leaves its low-power stop state and enters high-speed transmission. The lane's two single-ended lines arrive already decoded as a two-bit low-power state, together with a flag that says the high-speed receiver has seen the start of the HS-0 preamble. Both are sampled on a fast local clock. The block measures how many clock ticks the lane spends in the two low-power "low" states that must come between the stop state and high-speed entry. It compares that dwell against a programmable minimum and reports the result.

A measurement is armed by a one-cycle `arm` pulse, issued when a display pipeline is started. Once the clock lane runs continuously in high-speed mode, no further entry sequence occurs, so only the first entry after each arm is judged. Two tallies record how many entries were judged and how many of them were faulty, so a failure ratio across many pipeline starts can be read. An entry taken straight from the stop state, with no low-power low phase at all, is reported as a missing preamble. This is kept apart from a dwell that exists but is too short. A state sequence that breaks the required order is reported as a protocol error, and the monitor then waits for a fresh stop state.

Top module: `sot_dwell_monitor`

## Requirements
- R1: After synchronous reset, every output is zero and the monitor is disarmed: no result appears until `arm` has been pulsed.
- R2: The state code is `lp_state[1]` = positive line and `lp_state[0]` = negative line, so stop = 2'b11, request = 2'b01 and bridge = 2'b00. An armed monitor that sees stop, then request, then bridge, then `hs_active` high produces a one-cycle `result_valid` in the cycle after the first `hs_active` sample. With it, `dwell_ticks` equals the number of cycles sampled in the request and bridge states.
- R3: For a result reached through the request and bridge states, `dwell_short` is 1 exactly when `dwell_ticks` is below `min_ticks`; `preamble_missing` is 0.
- R4: If `hs_active` is sampled high while the lane is in the stop state, the result has `preamble_missing` = 1, `dwell_ticks` = 0 and `dwell_short` = 0. `hs_active` takes precedence over `lp_state` in that cycle.
- R5: After a result, the monitor ignores all lane activity until the next `arm`: no further `result_valid`, and the tallies do not change.
- R6: `entry_count` increases by one for every result, and `fault_count` for every result with `dwell_short` or `preamble_missing` set. Both saturate at their all-ones value.
- R7: The dwell measurement saturates at its all-ones value instead of wrapping.
- R8: Any state other than the expected next one or a repeat of the current one, including `hs_active` during the request state, gives a one-cycle `proto_err` pulse with no result and no tally change. The monitor stays armed and waits for the stop state again.
- R9: `arm` takes precedence over everything else and restarts the measurement from waiting for the stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse: judge the next entry |
| lp_state | input | 2 | Decoded low-power line state {P, N} |
| hs_active | input | 1 | High-speed preamble detected |
| min_ticks | input | DWELL_W | Minimum accepted dwell in ticks |
| result_valid | output | 1 | One-cycle pulse with a new result |
| dwell_ticks | output | DWELL_W | Measured low-power low dwell |
| dwell_short | output | 1 | Dwell below `min_ticks` |
| preamble_missing | output | 1 | HS entered directly from stop |
| proto_err | output | 1 | One-cycle pulse on an out-of-order state |
| entry_count | output | TALLY_W | Judged entries, saturating |
| fault_count | output | TALLY_W | Faulty entries, saturating |

## Verification
Random sessions vary the request and bridge lengths on both sides of the minimum. This separates a correct count, an off-by-one in the result cycle and a wrong comparison sense. Zero-length sessions separate a missing preamble from a short dwell, and an over-long session shows saturation rather than wrap. Directed runs place the bridge state straight after stop, HS right after request, and repeated HS after a result. These show that protocol errors and post-result activity leave the tallies alone, and enough sessions are run to push the tallies into saturation.

// File: rtl/sot_mon_pkg.sv
package sot_mon_pkg;
  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_WAIT   = 3'd1,
    PH_STOP   = 3'd2,
    PH_REQ    = 3'd3,
    PH_BRIDGE = 3'd4
  } phase_t;

  localparam logic [1:0] LP_STOP   = 2'b11;
  localparam logic [1:0] LP_REQ    = 2'b01;
  localparam logic [1:0] LP_BRIDGE = 2'b00;

  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
    logic res_missing;
    logic res_timed;
    logic proto;
  } seq_ev_t;
endpackage

// File: rtl/sot_seq_fsm.sv
module sot_seq_fsm
  import sot_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       hs_active,
  input  logic [1:0] lp_state,
  output seq_ev_t    ev
);
  phase_t ph, nxt;

  always_comb begin
    ev  = '0;
    nxt = ph;
    if (arm) begin
      nxt    = PH_WAIT;
      ev.clr = 1'b1;
    end else begin
      case (ph)
        PH_WAIT: if (!hs_active && lp_state == LP_STOP) nxt = PH_STOP;
        PH_STOP: begin
          if (hs_active) begin
            ev.res_missing = 1'b1;
            nxt = PH_OFF;
          end else if (lp_state == LP_REQ) begin
            ev.load = 1'b1;
            nxt = PH_REQ;
          end else if (lp_state != LP_STOP) begin
            ev.proto = 1'b1;
            nxt = PH_WAIT;
          end
        end
        PH_REQ: begin
          if (hs_active) begin
            ev.proto = 1'b1;
            nxt = PH_WAIT;
          end else if (lp_state == LP_REQ) begin
            ev.inc = 1'b1;
          end else if (lp_state == LP_BRIDGE) begin
            ev.inc = 1'b1;
            nxt = PH_BRIDGE;
          end else begin
            ev.proto = 1'b1;
            nxt = PH_WAIT;
          end
        end
        PH_BRIDGE: begin
          if (hs_active) begin
            ev.res_timed = 1'b1;
            nxt = PH_OFF;
          end else if (lp_state == LP_BRIDGE) begin
            ev.inc = 1'b1;
          end else begin
            ev.proto = 1'b1;
            nxt = PH_WAIT;
          end
        end
        default: nxt = ph;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_OFF;
    else     ph <= nxt;
  end

  // R5: a finished monitor stays idle until re-armed
  p_idle_until_arm_r5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_OFF && !arm) |=> (ph == PH_OFF));

  // R9: arm always restarts at the stop-wait phase
  p_arm_restart_r9: assert property (@(posedge clk) disable iff (rst)
    arm |=> (ph == PH_WAIT));
endmodule

// File: rtl/sot_dwell_counter.sv
module sot_dwell_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (load)                 cnt <= ONE;
    else if (inc && cnt != CMAX)   cnt <= cnt + ONE;
  end

  // R7: a full count never wraps while counting
  p_dwell_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && inc && !clr && !load) |=> (cnt == CMAX));
endmodule

// File: rtl/sot_tally.sv
module sot_tally #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst)                          cnt[i] <= '0;
      else if (inc[i] && cnt[i] != CMAX) cnt[i] <= cnt[i] + W'(1);
    end

    // R6: tallies saturate instead of wrapping
    p_tally_sat_r6: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] == CMAX) |=> (cnt[i] == CMAX));
  end
endmodule

// File: rtl/sot_dwell_monitor.sv
module sot_dwell_monitor
  import sot_mon_pkg::*;
#(
  parameter int DWELL_W = 8,
  parameter int TALLY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic [1:0]         lp_state,
  input  logic               hs_active,
  input  logic [DWELL_W-1:0] min_ticks,
  output logic               result_valid,
  output logic [DWELL_W-1:0] dwell_ticks,
  output logic               dwell_short,
  output logic               preamble_missing,
  output logic               proto_err,
  output logic [TALLY_W-1:0] entry_count,
  output logic [TALLY_W-1:0] fault_count
);
  localparam int NT = 2;

  seq_ev_t                    ev;
  logic [DWELL_W-1:0]         cnt;
  logic                       below_min;
  logic [NT-1:0]              tally_inc;
  logic [NT-1:0][TALLY_W-1:0] tally;

  sot_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .arm(arm), .hs_active(hs_active),
    .lp_state(lp_state), .ev(ev)
  );

  sot_dwell_counter #(.W(DWELL_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(ev.clr), .load(ev.load), .inc(ev.inc),
    .cnt(cnt)
  );

  assign below_min    = cnt < min_ticks;
  assign tally_inc[0] = ev.res_missing | ev.res_timed;
  assign tally_inc[1] = ev.res_missing | (ev.res_timed & below_min);

  sot_tally #(.W(TALLY_W), .N(NT)) u_tally (
    .clk(clk), .rst(rst), .inc(tally_inc), .cnt(tally)
  );

  assign entry_count = tally[0];
  assign fault_count = tally[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid     <= 1'b0;
      dwell_ticks      <= '0;
      dwell_short      <= 1'b0;
      preamble_missing <= 1'b0;
      proto_err        <= 1'b0;
    end else begin
      result_valid <= ev.res_missing | ev.res_timed;
      proto_err    <= ev.proto;
      if (ev.res_missing) begin
        dwell_ticks      <= '0;
        dwell_short      <= 1'b0;
        preamble_missing <= 1'b1;
      end else if (ev.res_timed) begin
        dwell_ticks      <= cnt;
        dwell_short      <= below_min;
        preamble_missing <= 1'b0;
      end
    end
  end

  // R2: the result strobe lasts one cycle
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R4: a missing preamble reports zero dwell and no short flag
  p_missing_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (result_valid && preamble_missing) |-> (dwell_ticks == '0 && !dwell_short));

  // R3: short flag agrees with the minimum in force at the entry
  p_short_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !preamble_missing) |-> (dwell_short == (dwell_ticks < $past(min_ticks))));

  // R8: a protocol error never coincides with a result
  p_err_no_result_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> !result_valid);

  // R6: faults never outnumber entries
  p_fault_le_entry_r6: assert property (@(posedge clk) disable iff (rst)
    fault_count <= entry_count);

  // R6: tallies move only with a result
  p_tally_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(ev.res_missing) && !$past(ev.res_timed)) |-> $stable(entry_count));
endmodule

// File: tb/sot_dwell_monitor_bench.sv
module sot_dwell_monitor_bench;
  localparam int DW = 8;
  localparam int TW = 6;
  localparam int DMAX = (1 << DW) - 1;
  localparam int TMAX = (1 << TW) - 1;

  logic          clk = 0;
  logic          rst = 1;
  logic          arm = 0;
  logic [1:0]    lp_state = 2'b11;
  logic          hs_active = 0;
  logic [DW-1:0] min_ticks = 8'd7;
  logic          result_valid, dwell_short, preamble_missing, proto_err;
  logic [DW-1:0] dwell_ticks;
  logic [TW-1:0] entry_count, fault_count;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int exp_entries = 0;
  int exp_faults = 0;

  always #4 clk = ~clk;

  sot_dwell_monitor #(.DWELL_W(DW), .TALLY_W(TW)) u_sot_dwell_monitor (
    .clk(clk), .rst(rst), .arm(arm), .lp_state(lp_state), .hs_active(hs_active),
    .min_ticks(min_ticks), .result_valid(result_valid), .dwell_ticks(dwell_ticks),
    .dwell_short(dwell_short), .preamble_missing(preamble_missing),
    .proto_err(proto_err), .entry_count(entry_count), .fault_count(fault_count)
  );

  function automatic int exp_dwell(int a, int b);
    return (a + b > DMAX) ? DMAX : a + b;
  endfunction

  function automatic int sat_t(int v);
    return (v > TMAX) ? TMAX : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] lp, logic hs, logic a);
    @(negedge clk);
    lp_state = lp; hs_active = hs; arm = a;
  endtask

  task automatic check_tallies(string req);
    check({req, " entry_count"}, int'(entry_count), sat_t(exp_entries));
    check({req, " fault_count"}, int'(fault_count), sat_t(exp_faults));
  endtask

  // arm, stop, a request cycles, b bridge cycles, then HS (lane code hs_lp)
  task automatic session(int a, int b, logic [1:0] hs_lp);
    int d;
    drive(2'b11, 0, 1);
    repeat (2) drive(2'b11, 0, 0);
    for (int i = 0; i < a; i++) drive(2'b01, 0, 0);
    for (int i = 0; i < b; i++) drive(2'b00, 0, 0);
    drive(hs_lp, 1, 0);
    @(posedge clk); #1;
    check("R2 valid", int'(result_valid), 1);
    if (a == 0) begin
      check("R4 missing", int'(preamble_missing), 1);
      check("R4 dwell", int'(dwell_ticks), 0);
      check("R4 short", int'(dwell_short), 0);
      exp_faults++;
    end else begin
      d = exp_dwell(a, b);
      check("R2 dwell", int'(dwell_ticks), d);
      check("R3 short", int'(dwell_short), (d < int'(min_ticks)) ? 1 : 0);
      check("R3 missing", int'(preamble_missing), 0);
      if (d < int'(min_ticks)) exp_faults++;
    end
    exp_entries++;
    drive(2'b11, 1, 0);
    #5;
    check("R2 pulse", int'(result_valid), 0);
    check_tallies("R6");
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int a, b;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", int'(result_valid), 0);
    check("R1 dwell", int'(dwell_ticks), 0);
    check("R1 entries", int'(entry_count), 0);
    check("R1 faults", int'(fault_count), 0);
    drive(2'b11, 0, 0);
    rst = 0;
    // R1: disarmed after reset, HS entry is ignored
    repeat (3) drive(2'b11, 0, 0);
    drive(2'b01, 1, 0);
    @(posedge clk); #1;
    check("R1 no result unarmed", int'(result_valid), 0);

    // R4 with lane code showing request: hs wins (R9-style precedence)
    session(0, 0, 2'b01);
    // R2/R3 directed: exactly at minimum, one below
    session(3, 4, 2'b00);
    session(3, 3, 2'b00);
    // R7: saturation
    session(100, 200, 2'b00);

    // R5: activity after result ignored
    repeat (2) drive(2'b11, 0, 0);
    drive(2'b01, 0, 0); drive(2'b00, 0, 0);
    drive(2'b00, 1, 0);
    @(posedge clk); #1;
    check("R5 no result", int'(result_valid), 0);
    drive(2'b11, 0, 0);
    #5;
    check_tallies("R5");

    // R8: bridge straight after stop
    drive(2'b11, 0, 1);
    drive(2'b11, 0, 0);
    drive(2'b00, 0, 0);
    @(posedge clk); #1;
    check("R8 err bridge", int'(proto_err), 1);
    check("R8 no result", int'(result_valid), 0);
    // R8: HS during request
    drive(2'b11, 0, 0);
    drive(2'b01, 0, 0);
    drive(2'b01, 1, 0);
    @(posedge clk); #1;
    check("R8 err hs in req", int'(proto_err), 1);
    drive(2'b11, 0, 0);
    #5;
    check("R8 err pulse", int'(proto_err), 0);
    check_tallies("R8");
    // R8: still armed, a clean entry now completes
    drive(2'b11, 0, 0);
    drive(2'b01, 0, 0); drive(2'b01, 0, 0);
    for (int i = 0; i < 6; i++) drive(2'b00, 0, 0);
    drive(2'b00, 1, 0);
    @(posedge clk); #1;
    check("R8 rearm result", int'(result_valid), 1);
    check("R8 rearm dwell", int'(dwell_ticks), 8);
    exp_entries++;
    drive(2'b11, 0, 0);

    // R9: arm in mid-measurement restarts
    drive(2'b11, 0, 1);
    drive(2'b11, 0, 0);
    drive(2'b01, 0, 0); drive(2'b01, 0, 0);
    drive(2'b01, 0, 1);
    drive(2'b01, 1, 0);
    @(posedge clk); #1;
    check("R9 restart no result", int'(result_valid), 0);
    check("R9 restart no err", int'(proto_err), 0);

    // random sessions, enough to saturate the tallies (R6)
    for (int n = 0; n < 70; n++) begin
      min_ticks = 8'(4 + ($urandom % 6));
      if (($urandom % 5) == 0) begin
        a = 0; b = 0;
      end else begin
        a = 1 + ($urandom % 8);
        b = 1 + ($urandom % 8);
      end
      session(a, b, 2'(($urandom % 4)));
    end
    check("R6 entry saturated", int'(entry_count), TMAX);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule